// File: doc/BRIEF.md
# Late Physical Register Allocator

This block renames destination registers without spending storage on them. At rename, a logical register is given a fresh virtual tag, and a register map table records the link from logical register to tag. No physical register is taken at this point. A physical register is bound to the tag only when the producing instruction completes and asks for one. A virtual map table holds that binding as a physical index plus a bound flag. Consumers carry the virtual tag of each source operand and resolve it through a combinational read port.

Physical registers come from a bitmap free list, and the lowest free index is taken first. One further register is kept apart as a reserve. Only a completion marked as coming from the oldest in-flight instruction may use it. This keeps forward progress when the pool runs dry. A completion that cannot be served is refused, and the instruction re-executes later. At commit, the caller hands back the superseded virtual tag. That tag is freed, and the physical register behind it, if one was ever bound, is recycled. A recycled register refills an empty reserve before it goes to the free list. A flush empties both map tables and restores the pool.

Rename and completion are valid/ready ports. A request fires only in a cycle where valid and ready are both high. While ready is low, the requester keeps its request and retries; nothing is queued inside. Ready on both ports is a combinational function of current state and of the request's own qualifiers, and it is low while flush is high. Commit, flush and the read port are plain control pins.

Top module: `late_preg_alloc`

## Requirements
- R1: `ren_ready` is high when any virtual tag is free and flush is low. A fired rename returns the lowest-numbered free tag on `ren_vtag` in the same cycle, and that tag is no longer offered afterwards. Renaming never changes which physical registers a completion can obtain.
- R2: `ren_prev_valid`/`ren_prev_vtag` show the tag currently mapped to `ren_lreg`, from the last rename of that logical register. After reset or flush, no logical register has a mapping.
- R3: A completion with `cpl_oldest`=0 is accepted only when the free list is non-empty. It is granted the lowest free physical index on `cpl_preg`, and from the next cycle its tag reads as bound to that index.
- R4: A refused completion (`cpl_ready`=0) changes nothing: its tag stays unbound and the pool is unchanged.
- R5: After reset, physical register 0 is the reserve and 1..N-1 are free. A general completion never takes the reserve. An oldest completion takes the lowest free index if there is one, and otherwise takes the reserve. It is refused only when both are empty.
- R6: A commit with `cmt_prev_valid`=1 whose previous tag is bound returns that physical register from the next cycle. It becomes the reserve if the reserve is empty, and otherwise it joins the free list. The previous tag reads unbound and becomes free for rename.
- R7: A commit whose previous tag was never bound frees the tag but returns no physical register.
- R8: Flush clears both map tables, frees every tag, makes register 0 the reserve and frees all other registers, effective from the next cycle. While flush is high, both ready outputs are low.
- R9: The read port gives `rd_bound`/`rd_preg` for `rd_vtag` in the same cycle.
- R10: Free-list entries plus the reserve plus bound tags always add up to the physical register count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all mappings and restore the pool |
| ren_valid | input | 1 | Rename request |
| ren_ready | output | 1 | A virtual tag is available |
| ren_lreg | input | LW | Destination logical register |
| ren_vtag | output | VW | Tag given to the rename |
| ren_prev_valid | output | 1 | `ren_lreg` had a mapping |
| ren_prev_vtag | output | VW | Previous tag of `ren_lreg` |
| cpl_valid | input | 1 | Completion asks for a physical register |
| cpl_ready | output | 1 | Request can be granted |
| cpl_oldest | input | 1 | Requester is the oldest in flight |
| cpl_vtag | input | VW | Tag of the completing instruction |
| cpl_preg | output | PW | Granted physical register |
| cmt_valid | input | 1 | An instruction commits |
| cmt_prev_valid | input | 1 | Committing instruction superseded a tag |
| cmt_prev_vtag | input | VW | Superseded tag to release |
| rd_vtag | input | VW | Source tag to resolve |
| rd_bound | output | 1 | Tag holds a physical register |
| rd_preg | output | PW | Bound physical register |

## Verification
The ready flags, the granted register, the rename tag, the previous mapping and the read port are combinational. So the bench drives a request at the falling edge and samples these outputs 1 ns later, within the same cycle. Bindings, releases, tag allocation and flush take effect at the next rising edge. The bench looks at them one cycle later, through the read port or by peeking at ready and grant with valid held low. It does not wait longer than that, so an update that arrives a cycle late shows up as a wrong value.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  // Where a completion grant is drawn from
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FREE = 2'd1,
    SRC_RSV  = 2'd2
  } grant_src_e;
endpackage

// File: rtl/lpa_lowest.sv
module lpa_lowest #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign found = |req;
endmodule

// File: rtl/lpa_pool.sv
module lpa_pool
  import lpa_pkg::*;
#(
  parameter int NP = 8,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int CW = $clog2(NP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          take,
  input  logic          take_oldest,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_preg,
  output logic          can_general,
  output logic          can_oldest,
  output logic [PW-1:0] grant_preg,
  output logic [CW-1:0] pool_cnt
);
  logic [NP-1:0] free_map, free_map_n;
  logic [PW-1:0] rsv_preg, rsv_preg_n;
  logic          rsv_valid, rsv_valid_n;
  logic          free_found;
  logic [PW-1:0] free_idx;
  grant_src_e    src;

  lpa_lowest #(.W(NP)) u_enc (.req(free_map), .found(free_found), .idx(free_idx));

  assign can_general = free_found;
  assign can_oldest  = free_found | rsv_valid;
  assign grant_preg  = free_found ? free_idx : rsv_preg;

  always_comb begin
    if (!take) src = SRC_NONE;
    else if (free_found) src = SRC_FREE;
    else src = SRC_RSV;
  end

  always_comb begin
    free_map_n  = free_map;
    rsv_preg_n  = rsv_preg;
    rsv_valid_n = rsv_valid;
    if (src == SRC_FREE) free_map_n[free_idx] = 1'b0;
    if (src == SRC_RSV)  rsv_valid_n = 1'b0;
    if (rel_valid) begin
      if (!rsv_valid_n) begin
        rsv_preg_n  = rel_preg;
        rsv_valid_n = 1'b1;
      end else begin
        free_map_n[rel_preg] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      free_map  <= {{(NP-1){1'b1}}, 1'b0};
      rsv_preg  <= '0;
      rsv_valid <= 1'b1;
    end else begin
      free_map  <= free_map_n;
      rsv_preg  <= rsv_preg_n;
      rsv_valid <= rsv_valid_n;
    end
  end

  assign pool_cnt = CW'($countones(free_map)) + CW'(rsv_valid);

  // R5
  rsv_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_oldest) |-> free_found);
  // R3
  free_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_FREE) |-> free_map[grant_preg]);
  // R5
  rsv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (rsv_valid && !rel_valid && src == SRC_RSV) |=> !rsv_valid);
endmodule

// File: rtl/lpa_vmt.sv
module lpa_vmt #(
  parameter int NV = 16,
  parameter int NP = 8,
  localparam int VW = (NV > 1) ? $clog2(NV) : 1,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int CW = $clog2(NV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          clr_en,
  input  logic [VW-1:0] clr_tag,
  input  logic          set_en,
  input  logic [VW-1:0] set_tag,
  input  logic [PW-1:0] set_preg,
  input  logic          rel_en,
  input  logic [VW-1:0] rel_tag,
  output logic          rel_bound,
  output logic [PW-1:0] rel_preg,
  input  logic [VW-1:0] rd_tag,
  output logic          rd_bound,
  output logic [PW-1:0] rd_preg,
  output logic [CW-1:0] bound_cnt
);
  logic [NV-1:0] bound;
  logic [PW-1:0] preg_of [NV];

  genvar g;
  generate
    for (g = 0; g < NV; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
          bound[g]   <= 1'b0;
          preg_of[g] <= '0;
        end else if (set_en && set_tag == VW'(g)) begin
          bound[g]   <= 1'b1;
          preg_of[g] <= set_preg;
        end else if ((clr_en && clr_tag == VW'(g)) ||
                     (rel_en && rel_tag == VW'(g))) begin
          bound[g] <= 1'b0;
        end
      end
    end
  endgenerate

  assign rd_bound  = bound[rd_tag];
  assign rd_preg   = preg_of[rd_tag];
  assign rel_bound = bound[rel_tag];
  assign rel_preg  = preg_of[rel_tag];
  assign bound_cnt = CW'($countones(bound));

  // R3
  bind_once_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    set_en |-> !bound[set_tag]);
  // R3
  bind_seen_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    set_en |=> bound[$past(set_tag)]);
endmodule

// File: rtl/late_preg_alloc.sv
module late_preg_alloc #(
  parameter int NUM_LREGS = 8,
  parameter int NUM_VTAGS = 16,
  parameter int NUM_PREGS = 8,
  localparam int LW = (NUM_LREGS > 1) ? $clog2(NUM_LREGS) : 1,
  localparam int VW = (NUM_VTAGS > 1) ? $clog2(NUM_VTAGS) : 1,
  localparam int PW = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [LW-1:0] ren_lreg,
  output logic [VW-1:0] ren_vtag,
  output logic          ren_prev_valid,
  output logic [VW-1:0] ren_prev_vtag,
  input  logic          cpl_valid,
  output logic          cpl_ready,
  input  logic          cpl_oldest,
  input  logic [VW-1:0] cpl_vtag,
  output logic [PW-1:0] cpl_preg,
  input  logic          cmt_valid,
  input  logic          cmt_prev_valid,
  input  logic [VW-1:0] cmt_prev_vtag,
  input  logic [VW-1:0] rd_vtag,
  output logic          rd_bound,
  output logic [PW-1:0] rd_preg
);
  localparam int PCW = $clog2(NUM_PREGS + 1);
  localparam int VCW = $clog2(NUM_VTAGS + 1);

  logic [NUM_LREGS-1:0] map_ok;
  logic [VW-1:0]        map_tag [NUM_LREGS];
  logic [NUM_VTAGS-1:0] tag_free;
  logic                 tag_found;
  logic                 ren_fire, cpl_fire, rel_fire;
  logic                 can_general, can_oldest, rel_bound;
  logic [PW-1:0]        rel_preg;
  logic [PCW-1:0]       pool_cnt;
  logic [VCW-1:0]       bound_cnt;

  lpa_lowest #(.W(NUM_VTAGS)) u_tag_enc (
    .req(tag_free), .found(tag_found), .idx(ren_vtag));

  assign ren_ready = tag_found && !flush;
  assign ren_fire  = ren_valid && ren_ready;
  assign ren_prev_valid = map_ok[ren_lreg];
  assign ren_prev_vtag  = map_tag[ren_lreg];

  assign cpl_ready = !flush && (cpl_oldest ? can_oldest : can_general);
  assign cpl_fire  = cpl_valid && cpl_ready;
  assign rel_fire  = cmt_valid && cmt_prev_valid && !flush;

  genvar l;
  generate
    for (l = 0; l < NUM_LREGS; l++) begin : g_rmt
      always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
          map_ok[l]  <= 1'b0;
          map_tag[l] <= '0;
        end else if (ren_fire && ren_lreg == LW'(l)) begin
          map_ok[l]  <= 1'b1;
          map_tag[l] <= ren_vtag;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      tag_free <= '1;
    end else begin
      if (ren_fire) tag_free[ren_vtag] <= 1'b0;
      if (rel_fire) tag_free[cmt_prev_vtag] <= 1'b1;
    end
  end

  lpa_vmt #(.NV(NUM_VTAGS), .NP(NUM_PREGS)) u_vmt (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .clr_en(ren_fire), .clr_tag(ren_vtag),
    .set_en(cpl_fire), .set_tag(cpl_vtag), .set_preg(cpl_preg),
    .rel_en(rel_fire), .rel_tag(cmt_prev_vtag),
    .rel_bound(rel_bound), .rel_preg(rel_preg),
    .rd_tag(rd_vtag), .rd_bound(rd_bound), .rd_preg(rd_preg),
    .bound_cnt(bound_cnt));

  lpa_pool #(.NP(NUM_PREGS)) u_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .take(cpl_fire), .take_oldest(cpl_oldest),
    .rel_valid(rel_fire && rel_bound), .rel_preg(rel_preg),
    .can_general(can_general), .can_oldest(can_oldest),
    .grant_preg(cpl_preg), .pool_cnt(pool_cnt));

  // R1
  tag_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |-> tag_free[ren_vtag]);
  // R1
  ren_no_preg_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (ren_fire && !cpl_fire && !rel_fire) |=> $stable(pool_cnt));
  // R10
  preg_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pool_cnt) + 32'(bound_cnt)) == NUM_PREGS);
  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!ren_ready && !cpl_ready));
endmodule

// File: tb/tb_late_preg_alloc.sv
`timescale 1ns/1ps
module tb_late_preg_alloc;
  localparam int NL = 4, NV = 8, NP = 4;
  localparam int LW = 2, VW = 3, PW = 2;

  logic clk = 0, rst_n = 0, flush = 0;
  logic ren_valid = 0, ren_ready, ren_prev_valid;
  logic [LW-1:0] ren_lreg = '0;
  logic [VW-1:0] ren_vtag, ren_prev_vtag;
  logic cpl_valid = 0, cpl_ready, cpl_oldest = 0;
  logic [VW-1:0] cpl_vtag = '0;
  logic [PW-1:0] cpl_preg;
  logic cmt_valid = 0, cmt_prev_valid = 0;
  logic [VW-1:0] cmt_prev_vtag = '0, rd_vtag = '0;
  logic rd_bound;
  logic [PW-1:0] rd_preg;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  late_preg_alloc #(.NUM_LREGS(NL), .NUM_VTAGS(NV), .NUM_PREGS(NP)) dut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_ren(int lr, int et, int epv, int ept);
    @(negedge clk); ren_valid = 1; ren_lreg = LW'(lr); #1;
    chk("R1 ready", int'(ren_ready), 1);
    chk("R1 tag", int'(ren_vtag), et);
    chk("R2 prev_valid", int'(ren_prev_valid), epv);
    if (epv != 0) chk("R2 prev_tag", int'(ren_prev_vtag), ept);
    @(posedge clk); #1 ren_valid = 0;
  endtask

  task automatic do_cpl(int t, int old, int erdy, int ep, string req);
    @(negedge clk); cpl_valid = 1; cpl_vtag = VW'(t); cpl_oldest = old[0]; #1;
    chk({req, " ready"}, int'(cpl_ready), erdy);
    if (erdy != 0) chk({req, " preg"}, int'(cpl_preg), ep);
    @(posedge clk); #1 cpl_valid = 0; cpl_oldest = 0;
  endtask

  task automatic peek_cpl(int old, int erdy, int ep, string req);
    @(negedge clk); cpl_valid = 0; cpl_oldest = old[0]; #1;
    chk({req, " ready"}, int'(cpl_ready), erdy);
    if (erdy != 0) chk({req, " preg"}, int'(cpl_preg), ep);
    cpl_oldest = 0;
  endtask

  task automatic do_cmt(int t);
    @(negedge clk); cmt_valid = 1; cmt_prev_valid = 1; cmt_prev_vtag = VW'(t);
    @(posedge clk); #1 cmt_valid = 0; cmt_prev_valid = 0;
  endtask

  task automatic chk_rd(int t, int eb, int ep, string req);
    @(negedge clk); rd_vtag = VW'(t); #1;
    chk({req, " bound"}, int'(rd_bound), eb);
    if (eb != 0) chk({req, " rd_preg"}, int'(rd_preg), ep);
  endtask

  task automatic chk_clean(string req);
    @(negedge clk); #1 chk({req, " ren_ready"}, int'(ren_ready), 1);
    for (int l = 0; l < NL; l++) begin
      ren_lreg = LW'(l); #1;
      chk({req, " no mapping"}, int'(ren_prev_valid), 0);
    end
    for (int t = 0; t < NV; t++) chk_rd(t, 0, 0, req);
    peek_cpl(0, 1, 1, {req, " R5 general skips reserve"});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_clean("R2 reset");
    // R1/R2: first use of each logical register, then supersede two
    for (int l = 0; l < NL; l++) do_ren(l, l, 0, 0);
    do_ren(0, 4, 1, 0);
    do_ren(1, 5, 1, 1);
    peek_cpl(0, 1, 1, "R1 rename keeps pool");
    // R3/R9: general grants lowest free
    do_cpl(0, 0, 1, 1, "R3");
    chk_rd(0, 1, 1, "R9");
    chk_rd(4, 0, 0, "R9 unbound");
    do_cpl(1, 0, 1, 2, "R3");
    do_cpl(2, 0, 1, 3, "R3");
    // R4: general refused with only the reserve left
    do_cpl(3, 0, 0, 0, "R4");
    chk_rd(3, 0, 0, "R4 unchanged");
    peek_cpl(1, 1, 0, "R4 reserve intact");
    // R5: oldest takes reserve
    do_cpl(3, 1, 1, 0, "R5");
    chk_rd(3, 1, 0, "R5");
    do_cpl(4, 1, 0, 0, "R5 empty");
    // R6: release refills reserve first
    do_cmt(0);
    chk_rd(0, 0, 0, "R6 unbound");
    peek_cpl(0, 0, 0, "R6 reserve first");
    peek_cpl(1, 1, 1, "R6 reserve");
    // R7: unbound prev returns nothing
    do_cmt(5);
    peek_cpl(0, 0, 0, "R7 general");
    peek_cpl(1, 1, 1, "R7 oldest");
    do_cpl(4, 1, 1, 1, "R5 oldest");
    chk_rd(4, 1, 1, "R5 read");
    // R6: second release goes to free list once reserve is full
    do_cmt(1);
    peek_cpl(0, 0, 0, "R6 into reserve");
    do_cmt(2);
    peek_cpl(0, 1, 3, "R6 free list");
    peek_cpl(1, 1, 3, "R5 oldest prefers free");
    // R1: drain tags lowest first
    begin
      int exp_tags[6] = '{0, 1, 2, 5, 6, 7};
      int prev = 2;
      foreach (exp_tags[i]) begin
        do_ren(2, exp_tags[i], 1, prev);
        prev = exp_tags[i];
      end
    end
    @(negedge clk); #1 chk("R1 exhausted", int'(ren_ready), 0);
    // R8: flush
    @(negedge clk); flush = 1; #1;
    chk("R8 ren blocked", int'(ren_ready), 0);
    cpl_oldest = 1; #1;
    chk("R8 cpl blocked", int'(cpl_ready), 0);
    cpl_oldest = 0;
    @(posedge clk); #1 flush = 0;
    chk_clean("R8 flush");
    peek_cpl(1, 1, 1, "R8 oldest");
    do_ren(0, 0, 0, 0);
    do_cpl(0, 0, 1, 1, "R8 grant");
    chk_rd(0, 1, 1, "R8 read");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule